// File: doc/BRIEF.md
# SCSI Initiator Command and Status Sequencer

This block is the command front end of a SCSI initiator controller. A host reaches a bank of byte-wide registers by direct address. Writing a byte to the command register starts one controller command. The commands are software reset, select, select-and-transfer, disconnect and a set of codes that have no effect. The block keeps a SCSI-status byte and an auxiliary-status byte for the host, and drives an interrupt flag from the top bit of the auxiliary status. That flag is cleared when the host reads the SCSI status, under the rules given below.

Target selection uses a request/response handshake with a target-side model. The block raises a request and presents the target number, an attention flag and an identify byte. The model answers with one of three results: no response, selected with the status phase next, or selected with a data or executing phase next. While a command is in progress, the command-in-progress bit locks out further commands. A busy flag, set when a target starts executing, blocks new select-and-transfer commands until the target releases it.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After reset the SCSI status reads 0x00, the auxiliary status (address 0x1F) reads 0x80 with `irq` high, every stored register reads 0x00, addresses 0x1B to 0x1E read 0xFF, and `sel_req` is low.
- R2: Command 0x00 clears addresses 0x01 to 0x1A and keeps the own-ID register (address 0x00). It sets the SCSI status to 0x01 when bit 3 of the own-ID register is 1, and to 0x00 otherwise. The auxiliary status is left unchanged.
- R3: Commands 0x06 and 0x07 set the SCSI status to 0x42 and the auxiliary status to 0x80, and clear the transfer-count bytes (0x12 to 0x14). No selection request is made.
- R4: Command 0x08 or 0x09 raises `sel_req` with `sel_tgt` equal to the low bits of the destination register (0x15). The auxiliary status reads 0x10 while the request waits. Command 0x08 drives `sel_atn` high and `sel_msg` equal to the target-LUN register (0x0F) ORed with 0x80. Command 0x09 drives `sel_atn` low. `sel_req` holds until `sel_ack`. An acknowledge with `sel_ok` low gives SCSI status 0x42, auxiliary status 0x80 and a cleared transfer count.
- R5: An acknowledge with `sel_ok` high is handled by `sel_phase`. With 0 (status), `sel_status` is stored in register 0x0F, the SCSI status becomes 0x16 and the auxiliary status becomes 0x80. With 1 (data), the auxiliary status becomes 0x31. With 2 (executing), it becomes 0x30.
- R6: In the executing phase, a `tgt_data_rdy` pulse raises bit 0 of the auxiliary status (giving 0x31). In the data or executing phase, a `tgt_done` pulse stores `tgt_status` in register 0x0F, sets the SCSI status to 0x16, sets the auxiliary status to 0x80 and clears the transfer count.
- R7: After an executing outcome, the target stays busy until a `tgt_release` pulse. Until then, command 0x08 or 0x09 reports status 0x42 and auxiliary status 0x80 and does not raise `sel_req`. A data outcome does not make the target busy.
- R8: A command written while auxiliary-status bit 4 is set is ignored. The command register and all other state stay unchanged.
- R9: A strobed read of the SCSI status (address 0x17) clears auxiliary bit 7 when the status is not 0x16. When the status is 0x16, the read returns 0x16, then changes the status to 0x85 and the auxiliary status to exactly 0x80.
- R10: Command 0x04 clears the transfer count and leaves the SCSI and auxiliary status unchanged.
- R11: Commands 0x02, 0x18 and every undefined code only store their value in the command register (0x18).
- R12: Host writes to addresses 0x01 to 0x16, 0x19 and 0x1A read back unchanged. Writes to 0x17 and to 0x1B to 0x1F have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (side effects on SCSI-status read) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq | output | 1 | Interrupt flag (auxiliary bit 7) |
| sel_req | output | 1 | Selection request to target model |
| sel_tgt | output | ID_W | Target number being selected |
| sel_atn | output | 1 | Attention requested with selection |
| sel_msg | output | 8 | Identify message byte |
| sel_ack | input | 1 | Target model answered this cycle |
| sel_ok | input | 1 | Selection succeeded |
| sel_phase | input | 2 | Next phase: 0 status, 1 data, 2 executing |
| sel_status | input | 8 | Status byte for the status-phase outcome |
| tgt_data_rdy | input | 1 | Data ready during executing phase |
| tgt_done | input | 1 | Target finished with status |
| tgt_status | input | 8 | Status byte returned at finish |
| tgt_release | input | 1 | Target no longer busy |

## Verification
The bench builds the block with its defaults: ADDR_W 5, ID_W 3 and TC_BYTES 3. With ID_W at 3, a destination byte of 0x0C or 0xFD shows that only the low three bits choose the target. With TC_BYTES at 3, all three count bytes 0x12 to 0x14 are counter bytes, so every clear path can be seen on the full count. Because the address width is exactly five bits, the constant 0xFF window and the auxiliary address are the top of the map.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

   // register positions the behaviour depends on
   localparam int unsigned A_OWN    = 0;
   localparam int unsigned A_LUN    = 15;
   localparam int unsigned A_TC_LO  = 20;
   localparam int unsigned A_DST    = 21;
   localparam int unsigned A_SS     = 23;
   localparam int unsigned A_CMD    = 24;
   localparam int unsigned A_CLRTOP = 26;
   localparam int unsigned A_AUX    = 31;

   // status codes
   localparam logic [7:0] SS_RST     = 8'h00;
   localparam logic [7:0] SS_RST_ADV = 8'h01;
   localparam logic [7:0] SS_DONE    = 8'h16;
   localparam logic [7:0] SS_SELTO   = 8'h42;
   localparam logic [7:0] SS_DISC    = 8'h85;

   localparam logic [7:0] AUX_INT = 8'h80;
   localparam logic [7:0] AUX_BSY = 8'h20;
   localparam logic [7:0] AUX_CIP = 8'h10;
   localparam logic [7:0] AUX_DBR = 8'h01;

   // command codes
   localparam logic [7:0] C_RESET    = 8'h00;
   localparam logic [7:0] C_DISC     = 8'h04;
   localparam logic [7:0] C_SEL_ATN  = 8'h06;
   localparam logic [7:0] C_SEL      = 8'h07;
   localparam logic [7:0] C_SELX_ATN = 8'h08;
   localparam logic [7:0] C_SELX     = 8'h09;

   // target outcome encoding
   localparam logic [1:0] OUT_STATUS = 2'd0;
   localparam logic [1:0] OUT_DATA   = 2'd1;
   localparam logic [1:0] OUT_EXEC   = 2'd2;

   typedef enum logic [1:0] {PH_FREE, PH_SELECT, PH_EXEC, PH_DATA} phase_t;

   typedef enum logic [2:0] {RK_OWN, RK_STORE, RK_CMD, RK_CONST, RK_CTRL} reg_kind_t;

   function automatic reg_kind_t reg_kind(input int unsigned a);
      if (a == A_OWN)                       return RK_OWN;
      else if (a == A_SS || a == A_AUX)     return RK_CTRL;
      else if (a == A_CMD)                  return RK_CMD;
      else if (a <= A_CLRTOP)               return RK_STORE;
      else                                  return RK_CONST;
   endfunction

endpackage

// File: rtl/scsi_seq_regbank.sv
module scsi_seq_regbank
   import scsi_seq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned TC_BYTES = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [7:0]                  wr_data,
   input  logic                        clr_all,
   input  logic                        tc_clr,
   input  logic                        cmd_we,
   input  logic [7:0]                  cmd_val,
   input  logic                        lun_ld,
   input  logic [7:0]                  lun_val,
   output logic [(1<<ADDR_W)*8-1:0]    rd_flat
);

   localparam int unsigned NREG     = 1 << ADDR_W;
   localparam int unsigned TC_FIRST = A_TC_LO - TC_BYTES + 1;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam reg_kind_t KIND   = reg_kind(i);
      localparam bit        IS_TC  = (i >= TC_FIRST) && (i <= A_TC_LO);
      localparam bit        IS_LUN = (i == A_LUN);

      if (KIND == RK_CMD) begin : g_cmd
         logic [7:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)      q <= '0;
            else if (cmd_we) q <= cmd_val;
         end
         assign rd_flat[i*8 +: 8] = q;
      end else if (KIND == RK_STORE || KIND == RK_OWN) begin : g_st
         logic [7:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (KIND == RK_STORE && clr_all) begin
               q <= '0;
            end else if (IS_TC && tc_clr) begin
               q <= '0;
            end else if (IS_LUN && lun_ld) begin
               q <= lun_val;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
               q <= wr_data;
            end
         end
         assign rd_flat[i*8 +: 8] = q;
      end else if (KIND == RK_CONST) begin : g_ff
         assign rd_flat[i*8 +: 8] = 8'hFF;
      end else begin : g_ctl
         assign rd_flat[i*8 +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/scsi_seq_ctrl.sv
module scsi_seq_ctrl
   import scsi_seq_pkg::*;
#(
   parameter int unsigned ID_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_go,
   input  logic [7:0]      cmd_code,
   input  logic            own_eaf,
   input  logic [ID_W-1:0] dst_id,
   input  logic [7:0]      lun_byte,
   input  logic            ss_rd,
   output logic [7:0]      ss_q,
   output logic [7:0]      aux_q,
   output logic            sel_req,
   output logic [ID_W-1:0] sel_tgt,
   output logic            sel_atn,
   output logic [7:0]      sel_msg,
   input  logic            sel_ack,
   input  logic            sel_ok,
   input  logic [1:0]      sel_phase,
   input  logic [7:0]      sel_status,
   input  logic            tgt_data_rdy,
   input  logic            tgt_done,
   input  logic [7:0]      tgt_status,
   input  logic            tgt_release,
   output logic            clr_all,
   output logic            tc_clr,
   output logic            lun_ld,
   output logic [7:0]      lun_val
);

   phase_t          st_q, st_n;
   logic [7:0]      ss_n, aux_n, msg_q, msg_n;
   logic [ID_W-1:0] tgt_q, tgt_n;
   logic            atn_q, atn_n, busy_q, busy_n;

   always_comb begin
      st_n    = st_q;
      ss_n    = ss_q;
      aux_n   = aux_q;
      msg_n   = msg_q;
      tgt_n   = tgt_q;
      atn_n   = atn_q;
      busy_n  = busy_q;
      clr_all = 1'b0;
      tc_clr  = 1'b0;
      lun_ld  = 1'b0;
      lun_val = '0;

      // status read-back side effects
      if (ss_rd) begin
         if (ss_q == SS_DONE) begin
            ss_n  = SS_DISC;
            aux_n = AUX_INT;
         end else begin
            aux_n[7] = 1'b0;
         end
      end

      if (tgt_release) busy_n = 1'b0;

      // command decode
      if (cmd_go) begin
         unique case (cmd_code)
            C_RESET: begin
               clr_all = 1'b1;
               tc_clr  = 1'b1;
               ss_n    = own_eaf ? SS_RST_ADV : SS_RST;
            end
            C_DISC: tc_clr = 1'b1;
            C_SEL_ATN, C_SEL: begin
               tgt_n  = dst_id;
               ss_n   = SS_SELTO;
               aux_n  = AUX_INT;
               tc_clr = 1'b1;
            end
            C_SELX_ATN, C_SELX: begin
               tgt_n = dst_id;
               if (busy_q) begin
                  ss_n   = SS_SELTO;
                  aux_n  = AUX_INT;
                  tc_clr = 1'b1;
               end else begin
                  st_n  = PH_SELECT;
                  aux_n = AUX_CIP;
                  atn_n = (cmd_code == C_SELX_ATN);
                  msg_n = lun_byte | 8'h80;
               end
            end
            default: ;
         endcase
      end

      // target-side progress
      unique case (st_q)
         PH_SELECT: if (sel_ack) begin
            if (!sel_ok) begin
               ss_n   = SS_SELTO;
               aux_n  = AUX_INT;
               tc_clr = 1'b1;
               st_n   = PH_FREE;
            end else if (sel_phase == OUT_STATUS) begin
               lun_ld  = 1'b1;
               lun_val = sel_status;
               ss_n    = SS_DONE;
               aux_n   = AUX_INT;
               tc_clr  = 1'b1;
               st_n    = PH_FREE;
            end else if (sel_phase == OUT_EXEC) begin
               aux_n  = AUX_CIP | AUX_BSY;
               busy_n = 1'b1;
               st_n   = PH_EXEC;
            end else begin
               aux_n = AUX_CIP | AUX_BSY | AUX_DBR;
               st_n  = PH_DATA;
            end
         end
         PH_EXEC, PH_DATA: begin
            if (tgt_done) begin
               lun_ld  = 1'b1;
               lun_val = tgt_status;
               ss_n    = SS_DONE;
               aux_n   = AUX_INT;
               tc_clr  = 1'b1;
               st_n    = PH_FREE;
            end else if (st_q == PH_EXEC && tgt_data_rdy) begin
               aux_n = aux_n | AUX_DBR;
               st_n  = PH_DATA;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PH_FREE;
         ss_q   <= SS_RST;
         aux_q  <= AUX_INT;
         msg_q  <= '0;
         tgt_q  <= '0;
         atn_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         ss_q   <= ss_n;
         aux_q  <= aux_n;
         msg_q  <= msg_n;
         tgt_q  <= tgt_n;
         atn_q  <= atn_n;
         busy_q <= busy_n;
      end
   end

   assign sel_req = (st_q == PH_SELECT);
   assign sel_tgt = tgt_q;
   assign sel_atn = atn_q;
   assign sel_msg = msg_q;

   p_selto_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go && (cmd_code == C_SEL || cmd_code == C_SEL_ATN)
      |=> ss_q == SS_SELTO && aux_q == AUX_INT);

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_req && !sel_ack |=> sel_req);

   p_exec_aux_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == PH_EXEC |-> aux_q == (AUX_CIP | AUX_BSY));

   p_busy_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go && (cmd_code == C_SELX || cmd_code == C_SELX_ATN) && busy_q && !tgt_release
      |=> !sel_req && ss_q == SS_SELTO);

   p_done_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_rd && ss_q == SS_DONE && !cmd_go && st_q == PH_FREE
      |=> ss_q == SS_DISC && aux_q == AUX_INT);

   p_rd_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ss_rd && ss_q != SS_DONE && !cmd_go && st_q == PH_FREE
      |=> !aux_q[7]);

endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
   import scsi_seq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned ID_W     = 3,
   parameter int unsigned TC_BYTES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              irq,
   output logic              sel_req,
   output logic [ID_W-1:0]   sel_tgt,
   output logic              sel_atn,
   output logic [7:0]        sel_msg,
   input  logic              sel_ack,
   input  logic              sel_ok,
   input  logic [1:0]        sel_phase,
   input  logic [7:0]        sel_status,
   input  logic              tgt_data_rdy,
   input  logic              tgt_done,
   input  logic [7:0]        tgt_status,
   input  logic              tgt_release
);

   localparam int unsigned NREG = 1 << ADDR_W;

   if (ADDR_W < 5) begin : g_chk_addr
      $error("ADDR_W must cover the 32-entry map");
   end
   if (ID_W < 1 || ID_W > 7) begin : g_chk_id
      $error("ID_W out of range");
   end
   if (TC_BYTES < 1 || TC_BYTES > 3) begin : g_chk_tc
      $error("TC_BYTES out of range");
   end

   logic [NREG*8-1:0] rd_flat;
   logic [7:0]        ss_q, aux_q, lun_val;
   logic              clr_all, tc_clr, lun_ld, cmd_go, ss_rd;

   assign cmd_go = host_wr && host_addr == ADDR_W'(A_CMD) && !aux_q[4];
   assign ss_rd  = host_rd && host_addr == ADDR_W'(A_SS);

   scsi_seq_regbank #(.ADDR_W(ADDR_W), .TC_BYTES(TC_BYTES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (host_wr),
      .wr_addr (host_addr),
      .wr_data (host_wdata),
      .clr_all (clr_all),
      .tc_clr  (tc_clr),
      .cmd_we  (cmd_go),
      .cmd_val (host_wdata),
      .lun_ld  (lun_ld),
      .lun_val (lun_val),
      .rd_flat (rd_flat)
   );

   scsi_seq_ctrl #(.ID_W(ID_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_go       (cmd_go),
      .cmd_code     (host_wdata),
      .own_eaf      (rd_flat[A_OWN*8+3]),
      .dst_id       (rd_flat[A_DST*8 +: ID_W]),
      .lun_byte     (rd_flat[A_LUN*8 +: 8]),
      .ss_rd        (ss_rd),
      .ss_q         (ss_q),
      .aux_q        (aux_q),
      .sel_req      (sel_req),
      .sel_tgt      (sel_tgt),
      .sel_atn      (sel_atn),
      .sel_msg      (sel_msg),
      .sel_ack      (sel_ack),
      .sel_ok       (sel_ok),
      .sel_phase    (sel_phase),
      .sel_status   (sel_status),
      .tgt_data_rdy (tgt_data_rdy),
      .tgt_done     (tgt_done),
      .tgt_status   (tgt_status),
      .tgt_release  (tgt_release),
      .clr_all      (clr_all),
      .tc_clr       (tc_clr),
      .lun_ld       (lun_ld),
      .lun_val      (lun_val)
   );

   always_comb begin
      if (host_addr == ADDR_W'(A_SS))       host_rdata = ss_q;
      else if (host_addr == ADDR_W'(A_AUX)) host_rdata = aux_q;
      else                                  host_rdata = rd_flat[host_addr*8 +: 8];
   end

   assign irq = aux_q[7];

   p_cip_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_addr == ADDR_W'(A_CMD) && aux_q[4]
      |=> $stable(rd_flat[A_CMD*8 +: 8]));

endmodule

// File: tb/scsi_cmd_seq_tb.sv
module scsi_cmd_seq_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] host_addr = '0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       irq, sel_req, sel_atn;
   logic [2:0] sel_tgt;
   logic [7:0] sel_msg;
   logic       sel_ack = 1'b0, sel_ok = 1'b0;
   logic [1:0] sel_phase = '0;
   logic [7:0] sel_status = '0;
   logic       tgt_data_rdy = 1'b0, tgt_done = 1'b0, tgt_release = 1'b0;
   logic [7:0] tgt_status = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scsi_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .sel_req(sel_req), .sel_tgt(sel_tgt), .sel_atn(sel_atn),
      .sel_msg(sel_msg), .sel_ack(sel_ack), .sel_ok(sel_ok),
      .sel_phase(sel_phase), .sel_status(sel_status),
      .tgt_data_rdy(tgt_data_rdy), .tgt_done(tgt_done),
      .tgt_status(tgt_status), .tgt_release(tgt_release)
   );

   // {address, write data, expected read-back}
   localparam logic [23:0] VEC [0:13] = '{
      24'h01a5a5, 24'h053c3c, 24'h0f0707, 24'h121111, 24'h132222,
      24'h143333, 24'h15fdfd, 24'h165a5a, 24'h19c3c3, 24'h1a9696,
      24'h17ee00, 24'h1b12ff, 24'h1e00ff, 24'h1f0080
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic peek(input logic [4:0] a, output logic [7:0] v);
      host_addr = a;
      #1;
      v = host_rdata;
   endtask

   task automatic rd_ss(output logic [7:0] v);
      host_addr = 5'h17; host_rd = 1'b1;
      #1;
      v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic ack(input logic ok, input logic [1:0] ph, input logic [7:0] st);
      sel_ack = 1'b1; sel_ok = ok; sel_phase = ph; sel_status = st;
      @(negedge clk);
      sel_ack = 1'b0; sel_ok = 1'b0;
   endtask

   task automatic finish_target(input logic [7:0] st);
      tgt_done = 1'b1; tgt_status = st;
      @(negedge clk);
      tgt_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek(5'h17, v); chk("R1 ss", v, 8'h00);
      peek(5'h1f, v); chk("R1 aux", v, 8'h80);
      chk("R1 irq", {7'd0, irq}, 8'h01);
      peek(5'h05, v); chk("R1 reg", v, 8'h00);
      peek(5'h1c, v); chk("R1 const", v, 8'hff);
      chk("R1 req", {7'd0, sel_req}, 8'h00);

      // R12 register table
      for (int i = 0; i < 14; i++) begin
         wr(VEC[i][23:16], VEC[i][15:8]);
         peek(VEC[i][23:16], v);
         chk("R12 table", v, VEC[i][7:0]);
      end

      // R3 select without transfer
      wr(5'h18, 8'h07);
      peek(5'h17, v); chk("R3 ss", v, 8'h42);
      peek(5'h1f, v); chk("R3 aux", v, 8'h80);
      peek(5'h12, v); chk("R3 tc hi", v, 8'h00);
      peek(5'h14, v); chk("R3 tc lo", v, 8'h00);
      chk("R3 no req", {7'd0, sel_req}, 8'h00);

      // R9 read of non-complete status clears interrupt
      rd_ss(v); chk("R9 ss value", v, 8'h42);
      peek(5'h1f, v); chk("R9 aux cleared", v, 8'h00);
      peek(5'h17, v); chk("R9 ss kept", v, 8'h42);

      // R2 reset command with and without advanced bit
      wr(5'h00, 8'h08);
      wr(5'h05, 8'h77);
      wr(5'h18, 8'h00);
      peek(5'h17, v); chk("R2 ss adv", v, 8'h01);
      peek(5'h05, v); chk("R2 cleared", v, 8'h00);
      peek(5'h15, v); chk("R2 dst cleared", v, 8'h00);
      peek(5'h00, v); chk("R2 own kept", v, 8'h08);
      peek(5'h1f, v); chk("R2 aux kept", v, 8'h00);
      wr(5'h00, 8'h00);
      wr(5'h18, 8'h00);
      peek(5'h17, v); chk("R2 ss plain", v, 8'h00);

      // R10 disconnect clears count only
      wr(5'h14, 8'h55);
      wr(5'h12, 8'h01);
      wr(5'h18, 8'h04);
      peek(5'h14, v); chk("R10 tc lo", v, 8'h00);
      peek(5'h12, v); chk("R10 tc hi", v, 8'h00);
      peek(5'h17, v); chk("R10 ss", v, 8'h00);
      peek(5'h1f, v); chk("R10 aux", v, 8'h00);

      // R11 no-effect commands
      wr(5'h18, 8'h02);
      peek(5'h18, v); chk("R11 cmd 02", v, 8'h02);
      peek(5'h17, v); chk("R11 ss", v, 8'h00);
      wr(5'h18, 8'h18);
      peek(5'h18, v); chk("R11 cmd 18", v, 8'h18);
      wr(5'h18, 8'h3f);
      peek(5'h18, v); chk("R11 cmd 3f", v, 8'h3f);
      peek(5'h1f, v); chk("R11 aux", v, 8'h00);

      // R4 select and transfer with ATN, timeout
      wr(5'h15, 8'h02);
      wr(5'h0f, 8'h03);
      wr(5'h14, 8'h09);
      wr(5'h18, 8'h08);
      chk("R4 req", {7'd0, sel_req}, 8'h01);
      chk("R4 tgt", {5'd0, sel_tgt}, 8'h02);
      chk("R4 atn", {7'd0, sel_atn}, 8'h01);
      chk("R4 msg", sel_msg, 8'h83);
      peek(5'h1f, v); chk("R4 aux wait", v, 8'h10);
      // R8 command during CIP ignored
      wr(5'h18, 8'h00);
      peek(5'h18, v); chk("R8 cmd kept", v, 8'h08);
      peek(5'h14, v); chk("R8 tc kept", v, 8'h09);
      chk("R4 req held", {7'd0, sel_req}, 8'h01);
      ack(1'b0, 2'd0, 8'h00);
      chk("R4 req drop", {7'd0, sel_req}, 8'h00);
      peek(5'h17, v); chk("R4 ss timeout", v, 8'h42);
      peek(5'h1f, v); chk("R4 aux timeout", v, 8'h80);
      peek(5'h14, v); chk("R4 tc cleared", v, 8'h00);

      // R5 straight to status
      wr(5'h15, 8'h0c);
      wr(5'h18, 8'h09);
      chk("R4 no atn", {7'd0, sel_atn}, 8'h00);
      chk("R4 tgt low bits", {5'd0, sel_tgt}, 8'h04);
      ack(1'b1, 2'd0, 8'h02);
      peek(5'h0f, v); chk("R5 lun status", v, 8'h02);
      peek(5'h17, v); chk("R5 ss done", v, 8'h16);
      peek(5'h1f, v); chk("R5 aux int", v, 8'h80);
      rd_ss(v); chk("R9 read done", v, 8'h16);
      peek(5'h17, v); chk("R9 ss flips", v, 8'h85);
      peek(5'h1f, v); chk("R9 aux exact", v, 8'h80);
      rd_ss(v);
      peek(5'h1f, v); chk("R9 clear after flip", v, 8'h00);

      // R5 data outcome, R6 completion, not busy
      wr(5'h14, 8'h44);
      wr(5'h18, 8'h09);
      ack(1'b1, 2'd1, 8'h00);
      peek(5'h1f, v); chk("R5 aux data", v, 8'h31);
      wr(5'h18, 8'h04);
      peek(5'h14, v); chk("R8 disc ignored", v, 8'h44);
      finish_target(8'h00);
      peek(5'h17, v); chk("R6 ss done", v, 8'h16);
      peek(5'h1f, v); chk("R6 aux int", v, 8'h80);
      peek(5'h14, v); chk("R6 tc cleared", v, 8'h00);
      rd_ss(v);
      wr(5'h18, 8'h09);
      chk("R7 data not busy", {7'd0, sel_req}, 8'h01);
      ack(1'b0, 2'd0, 8'h00);

      // R5 executing outcome, R6 data ready, R7 busy lockout
      wr(5'h18, 8'h08);
      ack(1'b1, 2'd2, 8'h00);
      peek(5'h1f, v); chk("R5 aux exec", v, 8'h30);
      tgt_data_rdy = 1'b1; @(negedge clk); tgt_data_rdy = 1'b0;
      peek(5'h1f, v); chk("R6 aux dbr", v, 8'h31);
      finish_target(8'h08);
      peek(5'h0f, v); chk("R6 lun", v, 8'h08);
      peek(5'h17, v); chk("R6 ss", v, 8'h16);
      rd_ss(v);
      wr(5'h18, 8'h08);
      chk("R7 no req", {7'd0, sel_req}, 8'h00);
      peek(5'h17, v); chk("R7 ss", v, 8'h42);
      peek(5'h1f, v); chk("R7 aux", v, 8'h80);
      tgt_release = 1'b1; @(negedge clk); tgt_release = 1'b0;
      wr(5'h18, 8'h09);
      chk("R7 released", {7'd0, sel_req}, 8'h01);
      ack(1'b0, 2'd0, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule